// File: doc/BRIEF.md
# Two-Level System-Management Interrupt Status Tree

This block gathers single-cycle event pulses from six second-level sources (two general-purpose timers, three user-defined I/O traps and one PCI trap) and from up to fifteen other top-level sources. Each event latches into a sticky status bit. Any pending second-level bit rolls up into one summary bit of a 16-bit top-level status word. An active-low interrupt line stays asserted while anything is pending at either level.

A handler reads the two levels through a small synchronous read port. Each level has two views that return the same data. The mirror view has no side effect. The read-to-clear view clears exactly the bits it returned. The handler reads the top level to find the branch, then reads the second level to find the actual source. The interrupt line is released only once both levels have been emptied.

Top module: `smi_status_tree`

## Requirements
- R1: After reset every status bit at both levels is zero, `smi_n` is 1 and `rd_data` is zero.
- R2: A pulse on `sub_evt[i]` sets second-level bit i at the next clock edge. The bit stays set until cleared. Second-level bit order: 0 timer one, 1 timer two, 2..4 user traps one to three, 5 PCI trap. Bits [15:6] of a second-level read are always 0.
- R3: Top-level bit 9 is set at the edge after any second-level bit is pending. A pulse on `misc_evt[k]` for k other than 9 sets top-level bit k at the next edge. `misc_evt[9]` has no effect.
- R4: `smi_n` is 0 whenever any status bit at either level is set. It returns to 1 only when both levels are entirely clear.
- R5: When `rd_en` is high at an edge, `rd_data` shows the addressed view after that edge. Offsets: 00h top mirror, 02h top read-to-clear, 04h second-level mirror, 06h second-level read-to-clear. Any other address returns 0. `rd_data` holds its value between reads.
- R6: A read of a mirror view (00h or 04h) never clears any status bit.
- R7: A read-to-clear clears, at the edge after the one that returned the data, exactly the bits that were returned. Bits set after that snapshot survive.
- R8: If a source event arrives at the edge where its bit is being cleared, the bit stays set.
- R9: If top-level bit 9 is cleared while a second-level bit is still pending, bit 9 sets again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_evt | input | 6 | Second-level event pulses |
| misc_evt | input | 16 | Other top-level event pulses, one per top bit (bit 9 unused) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Registered read data |
| smi_n | output | 1 | Active-low interrupt request |

## Verification
The hardest cases to reach are the ones where an event lands exactly on the edge where a read-to-clear takes effect. The same is true for a second-level bit that is still pending when the summary bit is cleared. Directed sequences place these on purpose. Reads are issued back to back so that a mirror read samples the word both just before and just after a clear. An event pulse is timed onto the clear edge, and another onto the snapshot edge. A long random phase then mixes events and reads at all offsets. A cycle-accurate behavioural model compares `smi_n` and `rd_data` against the block on every clock.

// File: rtl/smi_tree_pkg.sv
package smi_tree_pkg;
    localparam int REG_W    = 16;
    localparam int SUB_N    = 6;
    localparam int ROLL_BIT = 9;
    localparam int ADDR_W   = 8;

    localparam int OFF_TOP_MIR = 'h00;
    localparam int OFF_TOP_RTC = 'h02;
    localparam int OFF_SUB_MIR = 'h04;
    localparam int OFF_SUB_RTC = 'h06;
endpackage

// File: rtl/smi_stat_bank.sv
module smi_stat_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            // a set on the same edge as a clear keeps the bit
            st_d.stat[i] = set_i[i] | (st_q.stat[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/smi_reg_port.sv
module smi_reg_port
    import smi_tree_pkg::*;
#(
    parameter int RW  = REG_W,
    parameter int SN  = SUB_N,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [RW-1:0] top_i,
    input  logic [SN-1:0] sub_i,
    output logic [RW-1:0] rd_data_o,
    output logic [RW-1:0] clr_top_o,
    output logic [SN-1:0] clr_sub_o
);
    localparam int PAD_W = RW - SN;

    typedef struct packed {
        logic [RW-1:0] rdata;
        logic [RW-1:0] clr_top;
        logic [SN-1:0] clr_sub;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [RW-1:0] sub_wide;

    assign sub_wide = {{PAD_W{1'b0}}, sub_i};

    always_comb begin
        st_d         = st_q;
        st_d.clr_top = '0;
        st_d.clr_sub = '0;
        if (rd_en) begin
            if (rd_addr == AW'(OFF_TOP_MIR)) begin
                st_d.rdata = top_i;
            end else if (rd_addr == AW'(OFF_TOP_RTC)) begin
                st_d.rdata   = top_i;
                st_d.clr_top = top_i;
            end else if (rd_addr == AW'(OFF_SUB_MIR)) begin
                st_d.rdata = sub_wide;
            end else if (rd_addr == AW'(OFF_SUB_RTC)) begin
                st_d.rdata   = sub_wide;
                st_d.clr_sub = sub_i;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rdata;
    assign clr_top_o = st_q.clr_top;
    assign clr_sub_o = st_q.clr_sub;
endmodule

// File: rtl/smi_status_tree.sv
module smi_status_tree
    import smi_tree_pkg::*;
#(
    parameter int REG_W_P    = REG_W,
    parameter int SUB_N_P    = SUB_N,
    parameter int ROLL_BIT_P = ROLL_BIT,
    parameter int ADDR_W_P   = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SUB_N_P-1:0]  sub_evt,
    input  logic [REG_W_P-1:0]  misc_evt,
    input  logic                rd_en,
    input  logic [ADDR_W_P-1:0] rd_addr,
    output logic [REG_W_P-1:0]  rd_data,
    output logic                smi_n
);
    logic [SUB_N_P-1:0] sub_q, clr_sub;
    logic [REG_W_P-1:0] top_q, clr_top, top_set;

    // summary bit: a clear in progress wins for one edge, then re-arms
    always_comb begin
        top_set             = misc_evt;
        top_set[ROLL_BIT_P] = (|sub_q) & ~clr_top[ROLL_BIT_P];
    end

    smi_stat_bank #(.W(SUB_N_P)) u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sub_evt),
        .clr_i  (clr_sub),
        .stat_o (sub_q)
    );

    smi_stat_bank #(.W(REG_W_P)) u_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (top_set),
        .clr_i  (clr_top),
        .stat_o (top_q)
    );

    smi_reg_port #(.RW(REG_W_P), .SN(SUB_N_P), .AW(ADDR_W_P)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .top_i     (top_q),
        .sub_i     (sub_q),
        .rd_data_o (rd_data),
        .clr_top_o (clr_top),
        .clr_sub_o (clr_sub)
    );

    assign smi_n = ~((|top_q) | (|sub_q));
endmodule

// File: rtl/smi_tree_chk.sv
module smi_tree_chk
    import smi_tree_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int SN = SUB_N,
    parameter int RB = ROLL_BIT,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SN-1:0] sub_evt,
    input logic [RW-1:0] misc_evt,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [RW-1:0] rd_data,
    input logic          smi_n,
    input logic [RW-1:0] top_q,
    input logic [SN-1:0] sub_q,
    input logic [RW-1:0] clr_top,
    input logic [SN-1:0] clr_sub
);
    p_sub_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|sub_evt) |=> ((sub_q & $past(sub_evt)) == $past(sub_evt)));

    p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == AW'(OFF_SUB_RTC) || rd_addr == AW'(OFF_SUB_MIR)))
        |=> (rd_data[RW-1:SN] == '0));

    p_rollup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sub_q) && !clr_top[RB]) |=> top_q[RB]);

    p_no_spurious_roll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sub_q == '0) && !top_q[RB]) |=> !top_q[RB]);

    p_smi_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|sub_evt) |=> !smi_n);

    p_smi_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n) |-> $past((|sub_evt) || (|misc_evt)));

    p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == AW'(OFF_TOP_MIR) || rd_addr == AW'(OFF_SUB_MIR)))
        |=> (clr_top == '0 && clr_sub == '0));

    p_rtc_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == AW'(OFF_TOP_RTC)) |=> (clr_top == rd_data));

    p_sub_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_sub != '0) && (sub_evt == '0)) |=> ((sub_q & $past(clr_sub)) == '0));

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sub_evt & clr_sub)) |=> ((sub_q & $past(sub_evt & clr_sub)) == $past(sub_evt & clr_sub)));
endmodule

bind smi_status_tree smi_tree_chk #(
    .RW(REG_W_P), .SN(SUB_N_P), .RB(ROLL_BIT_P), .AW(ADDR_W_P)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sub_evt  (sub_evt),
    .misc_evt (misc_evt),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .smi_n    (smi_n),
    .top_q    (top_q),
    .sub_q    (sub_q),
    .clr_top  (clr_top),
    .clr_sub  (clr_sub)
);

// File: tb/tb_smi_status_tree.sv
`timescale 1ns/1ps
module tb_smi_status_tree;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sub_evt = '0;
    logic [15:0] misc_evt = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        smi_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    smi_status_tree dut (
        .clk(clk), .rst_n(rst_n), .sub_evt(sub_evt), .misc_evt(misc_evt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .smi_n(smi_n)
    );

    // behavioural reference built from the requirements
    logic [15:0] m_top, m_rd, m_ct;
    logic [5:0]  m_sub, m_cs;

    always @(posedge clk or negedge rst_n) begin
        logic [15:0] nt, nct, nrd;
        logic [5:0]  ns, ncs;
        if (!rst_n) begin
            m_top = '0; m_sub = '0; m_rd = '0; m_ct = '0; m_cs = '0;
        end else begin
            nt = (m_top & ~m_ct) | (misc_evt & 16'hFDFF);
            if (m_sub != 0 && !m_ct[9]) nt[9] = 1'b1;
            ns  = (m_sub & ~m_cs) | sub_evt;
            nct = '0; ncs = '0; nrd = m_rd;
            if (rd_en) begin
                case (rd_addr)
                    8'h00: nrd = m_top;
                    8'h02: begin nrd = m_top; nct = m_top; end
                    8'h04: nrd = {10'b0, m_sub};
                    8'h06: begin nrd = {10'b0, m_sub}; ncs = m_sub; end
                    default: nrd = '0;
                endcase
            end
            m_top = nt; m_sub = ns; m_rd = nrd; m_ct = nct; m_cs = ncs;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model smi_n", {15'b0, smi_n}, {15'b0, (m_top == 0 && m_sub == 0)});
            chk("R5 model rd_data", rd_data, m_rd);
        end
    end

    task automatic step(input logic [5:0] s, input logic [15:0] m,
                        input logic r, input logic [7:0] a);
        sub_evt = s; misc_evt = m; rd_en = r; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        sub_evt = '0; misc_evt = '0; rd_en = 1'b0; rd_addr = '0;
    endtask

    task automatic rdchk(input logic [7:0] a, input logic [15:0] exp, input string tag,
                         input logic [5:0] s = '0);
        step(s, '0, 1'b1, a);
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 smi_n after reset", {15'b0, smi_n}, 16'h0001);
        chk("R1 rd_data after reset", rd_data, 16'h0000);
        rdchk(8'h00, 16'h0000, "R1 top empty");
        rdchk(8'h06, 16'h0000, "R1 sub empty");

        // user trap one -> second-level bit 2, rolls into top bit 9
        step(6'b000100, '0, 1'b0, '0);
        rdchk(8'h04, 16'h0004, "R2 trap bit");
        rdchk(8'h00, 16'h0200, "R3 rollup bit 9");
        chk("R4 smi_n low while pending", {15'b0, smi_n}, 16'h0000);
        rdchk(8'h00, 16'h0200, "R6 mirror keeps top");
        rdchk(8'h02, 16'h0200, "R7 top rtc returns");
        rdchk(8'h00, 16'h0200, "R7 mirror before clear lands");
        rdchk(8'h00, 16'h0000, "R7 top cleared");
        rdchk(8'h00, 16'h0200, "R9 bit 9 re-arms");

        rdchk(8'h06, 16'h0004, "R7 sub rtc returns");
        rdchk(8'h04, 16'h0004, "R6 sub mirror before clear");
        rdchk(8'h04, 16'h0000, "R7 sub cleared");
        chk("R4 smi_n low with top only", {15'b0, smi_n}, 16'h0000);
        rdchk(8'h02, 16'h0200, "R4 top rtc");
        step('0, '0, 1'b0, '0);
        step('0, '0, 1'b0, '0);
        chk("R4 smi_n released", {15'b0, smi_n}, 16'h0001);

        // misc bit 9 ignored, other misc bits latch
        step('0, 16'h0200, 1'b0, '0);
        step('0, '0, 1'b0, '0);
        chk("R3 misc bit 9 no smi", {15'b0, smi_n}, 16'h0001);
        rdchk(8'h00, 16'h0000, "R3 misc bit 9 ignored");
        step('0, 16'h0008, 1'b0, '0);
        rdchk(8'h00, 16'h0008, "R3 misc bit 3");
        rdchk(8'h02, 16'h0008, "R7 misc rtc");
        step('0, '0, 1'b0, '0);
        rdchk(8'h00, 16'h0000, "R7 misc cleared");

        // event on the clear edge
        step(6'b000001, '0, 1'b0, '0);
        rdchk(8'h06, 16'h0001, "R8 sub rtc");
        step(6'b000001, '0, 1'b0, '0);
        rdchk(8'h04, 16'h0001, "R8 event wins");
        rdchk(8'h06, 16'h0001, "R8 drain");

        // event on the snapshot edge survives
        step(6'b000001, '0, 1'b0, '0);
        rdchk(8'h06, 16'h0001, "R7 snapshot excludes new", 6'b100000);
        rdchk(8'h04, 16'h0021, "R7 pre-clear view");
        rdchk(8'h04, 16'h0020, "R7 late bit survives");

        // unmapped addresses and hold
        rdchk(8'h08, 16'h0000, "R5 unmapped 08h");
        rdchk(8'h01, 16'h0000, "R5 unmapped 01h");
        rdchk(8'h04, 16'h0020, "R5 pci trap bit 5");
        step('0, '0, 1'b0, '0);
        chk("R5 rd_data holds", rd_data, 16'h0020);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic [5:0]  s;
            logic [15:0] m;
            logic [7:0]  a;
            s = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
            m = ($urandom % 8 == 0) ? (16'd1 << ($urandom % 16)) : 16'd0;
            case ($urandom % 6)
                0: a = 8'h00;
                1: a = 8'h02;
                2: a = 8'h04;
                3: a = 8'h06;
                4: a = 8'h0A;
                default: a = 8'h02;
            endcase
            step(s, m, ($urandom % 3 == 0), a);
        end
        finish_run();
    end
endmodule